// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a slave for a two-wire serial control bus, clocked by a fast system clock. It samples the bus clock and data lines, filters out short glitches, and finds start, repeated-start and stop conditions. It answers only to the fixed 7-bit device address 1000100. Each frame moves at most one data byte into or out of a small byte-wide register map. The data line is never driven high. The block only asks the pad to pull the line low, through an active-high pull-down enable.

The master writes a register by sending a start, the device address with a write direction bit, a register pointer byte, one data byte and a stop. To read, it writes the pointer, issues a repeated start with the read direction bit, and clocks out one byte. The map holds twelve writable configuration bytes, which are brought out on a flat output bus. It also holds two read-only status bytes that mirror external inputs. Bit 0 of register 0 shuts the serial port off. Only a reset brings it back.

Top module: `serial_reg_slave`

## Requirements
- R1: The first byte after a start is compared in bits 7:1 against 1000100, and bit 0 is the direction (0 write, 1 read). On a match the slave acknowledges. On a mismatch it leaves SDA released in the ninth slot and ignores every later byte until the next start or stop.
- R2: In a write frame, the second byte loads the register pointer and the third byte is stored at that pointer when it is 0x00 to 0x0B. Both bytes are acknowledged. The stored bytes appear on `cfgFlat`, with register n at bits 8n+7:8n.
- R3: Only one data byte is accepted per frame. Any further byte is not acknowledged and changes no register.
- R4: In a read frame, after the address acknowledge, the slave shifts out the byte at the current pointer, MSB first, changing SDA only while SCL is low. It releases SDA after the eighth bit. The pointer is kept from the previous write frame.
- R5: A repeated start in any state restarts address matching, including after a mismatched address byte.
- R6: Location 0x0E reads as {0000, rateCode} and 0x0F reads as {0, losCode}. Writes to 0x0C to 0x0F or to 0x10 and above are acknowledged but discarded. Reads of 0x0C, 0x0D and 0x10 and above return 0x00.
- R7: Once bit 0 of register 0 is 1, every frame that begins with a later start is ignored and SDA is never pulled low, until reset.
- R8: An acknowledge pulls SDA low from the SCL fall after the eighth bit until the ninth SCL fall. SDA does not change while SCL stays high.
- R9: After reset, all writable registers read 0x00 and SDA is released.
- R10: A stop returns the slave to idle with SDA released.
- R11: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks is not seen as an edge, so a one-clock SCL spike during a byte does not shift in an extra bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| rateCode | input | RATE_W | Status mirrored at location 0x0E |
| losCode | input | LOS_W | Status mirrored at location 0x0F |
| sdaPullLow | output | 1 | 1 enables the pad pull-down on SDA |
| cfgFlat | output | NUM_RW*8 | Writable registers, register n at bits 8n+7:8n |

## Verification
The assertions check four things on every cycle. SDA never moves while SCL is high, which covers both acknowledges and read data. SDA is released after every stop. Reset leaves the map cleared. Once the port has been switched off and a new start has been seen, the line is never pulled again.

The directed scenarios cover what only a whole frame can show. These are the address match and mismatch, the single-byte limit, pointer reuse across a repeated start, the status mirrors and discarded writes, and a clock spike that must not add a bit. Each is checked through the acknowledge bits, the read data and `cfgFlat`.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  // strobes the controller sends to the datapath, at most a few per cycle
  typedef struct packed {
    logic shiftBit;  // sample SDA into the receive shifter
    logic loadPtr;   // receive shifter -> register pointer
    logic writeReg;  // receive shifter -> register at pointer
    logic loadTx;    // read value at pointer -> transmit shifter
    logic shiftTx;   // advance transmit shifter by one bit
  } dpStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_DECIDE, S_ACK_SETUP, S_ACK_HOLD, S_TX, S_IGNORE
  } ctrlState_t;

  typedef enum logic [1:0] {
    K_DEV, K_REG, K_DATA
  } byteKind_t;

endpackage

// File: rtl/sreg_pin_filter.sv
module sreg_pin_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinOut
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] runCnt;

  // two-flop synchronizer, then accept a new level only after it has held
  // for FILT_LEN consecutive samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      runCnt <= '0;
      pinOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], pinIn};
      if (syncQ[1] != pinOut) begin
        if (runCnt == CNT_W'(FILT_LEN - 1)) begin
          pinOut <= syncQ[1];
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
  import sreg_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      devHit,
  input  logic      readReq,
  input  logic      busOff,
  input  logic      txBit,
  output dpStrobe_t strobe,
  output logic      sdaPullLow,
  output logic      startSeen,
  output logic      stopSeen
);
  logic sclF, sdaF, sclQ, sdaQ;
  logic sclRise, sclFall;

  sreg_pin_filter #(.FILT_LEN(FILT_LEN)) sclFilt (
    .clk(clk), .rstN(rstN), .pinIn(sclIn), .pinOut(sclF));
  sreg_pin_filter #(.FILT_LEN(FILT_LEN)) sdaFilt (
    .clk(clk), .rstN(rstN), .pinIn(sdaIn), .pinOut(sdaF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
    end
  end

  assign sclRise   = sclF & ~sclQ;
  assign sclFall   = ~sclF & sclQ;
  assign startSeen = sclF & sclQ & sdaQ & ~sdaF;
  assign stopSeen  = sclF & sclQ & ~sdaQ & sdaF;

  ctrlState_t state;
  byteKind_t  kind;
  logic [2:0] bitCnt;
  logic       readMode;
  logic       ackPull;
  logic       txOn;

  always_comb begin
    strobe          = '0;
    strobe.shiftBit = (state == S_RX) && sclRise;
    strobe.loadPtr  = (state == S_DECIDE) && (kind == K_REG);
    strobe.writeReg = (state == S_DECIDE) && (kind == K_DATA);
    strobe.loadTx   = (state == S_ACK_HOLD) && sclFall && (kind == K_DEV) && readMode;
    strobe.shiftTx  = (state == S_TX) && sclFall && (bitCnt != 3'd7);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      kind     <= K_DEV;
      bitCnt   <= '0;
      readMode <= 1'b0;
      ackPull  <= 1'b0;
      txOn     <= 1'b0;
    end else if (stopSeen) begin
      state   <= S_IDLE;
      ackPull <= 1'b0;
      txOn    <= 1'b0;
    end else if (startSeen) begin
      state   <= busOff ? S_IDLE : S_RX;
      kind    <= K_DEV;
      bitCnt  <= '0;
      ackPull <= 1'b0;
      txOn    <= 1'b0;
    end else begin
      case (state)
        S_RX: if (sclRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == 3'd7) state <= S_DECIDE;
        end
        S_DECIDE: begin
          if (kind == K_DEV) begin
            state    <= devHit ? S_ACK_SETUP : S_IGNORE;
            readMode <= readReq;
          end else begin
            state <= S_ACK_SETUP;
          end
        end
        S_ACK_SETUP: if (sclFall) begin
          ackPull <= 1'b1;
          state   <= S_ACK_HOLD;
        end
        S_ACK_HOLD: if (sclFall) begin
          ackPull <= 1'b0;
          bitCnt  <= '0;
          if (kind == K_DEV && readMode) begin
            txOn  <= 1'b1;
            state <= S_TX;
          end else if (kind == K_DEV) begin
            kind  <= K_REG;
            state <= S_RX;
          end else if (kind == K_REG) begin
            kind  <= K_DATA;
            state <= S_RX;
          end else begin
            state <= S_IGNORE;
          end
        end
        S_TX: if (sclFall) begin
          if (bitCnt == 3'd7) begin
            txOn  <= 1'b0;
            state <= S_IGNORE;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaPullLow = ackPull | (txOn & ~txBit);
endmodule

// File: rtl/sreg_datapath.sv
module sreg_datapath
  import sreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100,
  parameter int NUM_RW   = 12,
  parameter int RATE_LOC = 14,
  parameter int LOS_LOC  = 15,
  parameter int RATE_W   = 4,
  parameter int LOS_W    = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic                  sdaBit,
  input  logic [RATE_W-1:0]     rateCode,
  input  logic [LOS_W-1:0]      losCode,
  output logic                  devHit,
  output logic                  readReq,
  output logic                  busOff,
  output logic                  txBit,
  output logic [NUM_RW*8-1:0]   cfgFlat
);
  logic [7:0] rxShift;
  logic [7:0] txShift;
  logic [7:0] regPtr;
  logic [7:0] readVal;
  logic [7:0] cfgReg [NUM_RW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      regPtr  <= '0;
    end else begin
      if (strobe.shiftBit) rxShift <= {rxShift[6:0], sdaBit};
      if (strobe.loadPtr)  regPtr  <= rxShift;
      if (strobe.loadTx)   txShift <= readVal;
      else if (strobe.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  for (genvar g = 0; g < NUM_RW; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cfgReg[g] <= '0;
      else if (strobe.writeReg && regPtr == 8'(g))
        cfgReg[g] <= rxShift;
    end
    assign cfgFlat[g*8 +: 8] = cfgReg[g];
  end

  always_comb begin
    readVal = '0;
    for (int i = 0; i < NUM_RW; i++)
      if (regPtr == 8'(i)) readVal = cfgReg[i];
    if (regPtr == 8'(RATE_LOC)) readVal = 8'(rateCode);
    if (regPtr == 8'(LOS_LOC))  readVal = 8'(losCode);
  end

  assign devHit  = (rxShift[7:1] == DEV_ADDR);
  assign readReq = rxShift[0];
  assign busOff  = cfgReg[0][0];
  assign txBit   = txShift[7];
endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
  import sreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100,
  parameter int NUM_RW   = 12,
  parameter int RATE_LOC = 14,
  parameter int LOS_LOC  = 15,
  parameter int RATE_W   = 4,
  parameter int LOS_W    = 7,
  parameter int FILT_LEN = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic [RATE_W-1:0]   rateCode,
  input  logic [LOS_W-1:0]    losCode,
  output logic                sdaPullLow,
  output logic [NUM_RW*8-1:0] cfgFlat
);
  dpStrobe_t strobe;
  logic devHit, readReq, busOff, txBit;
  logic startSeen, stopSeen;

  sreg_ctrl #(.FILT_LEN(FILT_LEN)) ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .devHit(devHit), .readReq(readReq), .busOff(busOff), .txBit(txBit),
    .strobe(strobe), .sdaPullLow(sdaPullLow),
    .startSeen(startSeen), .stopSeen(stopSeen));

  // the receive shifter samples the raw pad level; by the time the filtered
  // rising edge arrives SDA has long been stable
  sreg_datapath #(
    .DEV_ADDR(DEV_ADDR), .NUM_RW(NUM_RW), .RATE_LOC(RATE_LOC),
    .LOS_LOC(LOS_LOC), .RATE_W(RATE_W), .LOS_W(LOS_W)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaIn),
    .rateCode(rateCode), .losCode(losCode),
    .devHit(devHit), .readReq(readReq), .busOff(busOff), .txBit(txBit),
    .cfgFlat(cfgFlat));
endmodule

// File: rtl/serial_reg_slave_chk.sv
module serial_reg_slave_chk #(
  parameter int NUM_RW = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                sclIn,
  input logic                sdaPullLow,
  input logic [NUM_RW*8-1:0] cfgFlat,
  input logic                startSeen,
  input logic                stopSeen
);
  logic portBlocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) portBlocked <= 1'b0;
    else if (startSeen && cfgFlat[0]) portBlocked <= 1'b1;
  end

  // R7
  port_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    portBlocked |-> !sdaPullLow);

  // R8
  sda_hold_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaPullLow));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaPullLow);

  // R9
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cfgFlat == '0 && !sdaPullLow));
endmodule

bind serial_reg_slave serial_reg_slave_chk #(.NUM_RW(NUM_RW)) chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .cfgFlat(cfgFlat), .startSeen(startSeen), .stopSeen(stopSeen));

// File: tb/serial_reg_slave_test.sv
module serial_reg_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 16;
  localparam logic [6:0] DEV = 7'b1000100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic masterSda = 1'b1;
  logic sdaBus;
  logic sdaPullLow;
  logic [3:0] rateCode = 4'h9;
  logic [6:0] losCode = 7'h55;
  logic [95:0] cfgFlat;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sdaBus = masterSda & ~sdaPullLow;

  serial_reg_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .rateCode(rateCode), .losCode(losCode),
    .sdaPullLow(sdaPullLow), .cfgFlat(cfgFlat));

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cfgByte(input int i);
    return cfgFlat[i*8 +: 8];
  endfunction

  task automatic busStart();
    masterSda = 1'b1; scl = 1'b1; wt(Q);
    masterSda = 1'b0; wt(Q);
    scl = 1'b0; wt(Q);
  endtask

  task automatic busRepStart();
    masterSda = 1'b1; wt(Q);
    scl = 1'b1; wt(Q);
    masterSda = 1'b0; wt(Q);
    scl = 1'b0; wt(Q);
  endtask

  task automatic busStop();
    masterSda = 1'b0; wt(Q);
    scl = 1'b1; wt(Q);
    masterSda = 1'b1; wt(2 * Q);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output bit acked);
    bit s1, s2;
    for (int i = 7; i >= 0; i--) begin
      masterSda = b[i];
      if (glitch && i == 3) begin
        wt(4); scl = 1'b1; wt(1); scl = 1'b0; wt(Q - 5);
      end else begin
        wt(Q);
      end
      scl = 1'b1; wt(2 * Q);
      scl = 1'b0; wt(Q);
    end
    masterSda = 1'b1; wt(Q);
    scl = 1'b1; wt(6);
    s1 = sdaBus; wt(2 * Q - 8);
    s2 = sdaBus; wt(2);
    scl = 1'b0; wt(Q);
    acked = !s1 && !s2;
  endtask

  task automatic recvByte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      masterSda = 1'b1; wt(Q);
      scl = 1'b1; wt(Q);
      b[i] = sdaBus; wt(Q);
      scl = 1'b0; wt(Q);
    end
    masterSda = 1'b1; wt(Q);
    scl = 1'b1; wt(2 * Q);
    scl = 1'b0; wt(Q);
  endtask

  task automatic writeFrame(input logic [6:0] dev, input logic [7:0] ptr, input logic [7:0] data,
                            input bit glitch, output bit a0, output bit a1, output bit a2);
    busStart();
    sendByte({dev, 1'b0}, 1'b0, a0);
    sendByte(ptr, 1'b0, a1);
    sendByte(data, glitch, a2);
    busStop();
  endtask

  task automatic readFrame(input logic [7:0] ptr, output logic [7:0] data, output bit allAck);
    bit a0, a1, a2;
    busStart();
    sendByte({DEV, 1'b0}, 1'b0, a0);
    sendByte(ptr, 1'b0, a1);
    busRepStart();
    sendByte({DEV, 1'b1}, 1'b0, a2);
    recvByte(data);
    busStop();
    allAck = a0 && a1 && a2;
  endtask

  task automatic testReset();
    chk(!sdaPullLow, "R9 sda released", 32'(sdaPullLow), 0);
    chk(cfgFlat == '0, "R9 registers cleared", cfgFlat[31:0], 0);
  endtask

  task automatic testWriteRead();
    bit a0, a1, a2, ok;
    logic [7:0] d;
    writeFrame(DEV, 8'h03, 8'hA5, 1'b0, a0, a1, a2);
    chk(a0, "R1 address ack", 32'(a0), 1);
    chk(a1 && a2, "R2 pointer and data ack", {a1, a2}, 2'b11);
    chk(cfgByte(3) == 8'hA5, "R2 reg3 stored", cfgByte(3), 8'hA5);
    chk(!sdaPullLow, "R10 idle after stop", 32'(sdaPullLow), 0);
    readFrame(8'h03, d, ok);
    chk(ok, "R5 acks around repeated start", 32'(ok), 1);
    chk(d == 8'hA5, "R4 read reg3", d, 8'hA5);
    writeFrame(DEV, 8'h0B, 8'h7E, 1'b0, a0, a1, a2);
    chk(cfgByte(11) == 8'h7E, "R2 top writable reg", cfgByte(11), 8'h7E);
    readFrame(8'h0B, d, ok);
    chk(d == 8'h7E, "R4 read reg 0x0B", d, 8'h7E);
  endtask

  task automatic testStatus();
    bit ok, a0, a1, a2;
    logic [7:0] d;
    readFrame(8'h0E, d, ok);
    chk(d == 8'h09, "R6 rate mirror", d, 8'h09);
    readFrame(8'h0F, d, ok);
    chk(d == 8'h55, "R6 los mirror", d, 8'h55);
    writeFrame(DEV, 8'h0E, 8'hFF, 1'b0, a0, a1, a2);
    chk(a2, "R6 read-only write acked", 32'(a2), 1);
    readFrame(8'h0E, d, ok);
    chk(d == 8'h09, "R6 read-only unchanged", d, 8'h09);
    writeFrame(DEV, 8'h20, 8'h3C, 1'b0, a0, a1, a2);
    chk(a2 && cfgByte(3) == 8'hA5 && cfgByte(11) == 8'h7E && cfgByte(0) == 8'h00,
        "R6 unmapped write discarded", cfgByte(3), 8'hA5);
    readFrame(8'h0C, d, ok);
    chk(d == 8'h00, "R6 unmapped read zero", d, 8'h00);
  endtask

  task automatic testMismatch();
    bit a0, a1, a2;
    writeFrame(7'b1000101, 8'h03, 8'h5A, 1'b0, a0, a1, a2);
    chk(!a0 && !a1 && !a2, "R1 mismatch no ack", {a0, a1, a2}, 0);
    chk(cfgByte(3) == 8'hA5, "R1 mismatch frame ignored", cfgByte(3), 8'hA5);
    busStart();
    sendByte({7'b0010001, 1'b0}, 1'b0, a0);
    busRepStart();
    sendByte({DEV, 1'b0}, 1'b0, a1);
    sendByte(8'h05, 1'b0, a2);
    chk(!a0 && a1, "R5 repeated start rematches", {a0, a1}, 2'b01);
    sendByte(8'hC3, 1'b0, a2);
    busStop();
    chk(cfgByte(5) == 8'hC3, "R5 write after rematch", cfgByte(5), 8'hC3);
  endtask

  task automatic testExtraByte();
    bit a0, a1, a2, a3;
    busStart();
    sendByte({DEV, 1'b0}, 1'b0, a0);
    sendByte(8'h02, 1'b0, a1);
    sendByte(8'h11, 1'b0, a2);
    sendByte(8'h22, 1'b0, a3);
    busStop();
    chk(a2 && !a3, "R3 second data byte nacked", {a2, a3}, 2'b10);
    chk(cfgByte(2) == 8'h11 && cfgByte(3) == 8'hA5, "R3 extra byte ignored", cfgByte(2), 8'h11);
  endtask

  task automatic testGlitch();
    bit a0, a1, a2;
    writeFrame(DEV, 8'h04, 8'h96, 1'b1, a0, a1, a2);
    chk(a2 && cfgByte(4) == 8'h96, "R11 scl spike filtered", cfgByte(4), 8'h96);
  endtask

  task automatic testDisable();
    bit a0, a1, a2;
    writeFrame(DEV, 8'h00, 8'h01, 1'b0, a0, a1, a2);
    chk(a2 && cfgByte(0) == 8'h01, "R7 disable bit stored", cfgByte(0), 8'h01);
    writeFrame(DEV, 8'h06, 8'h44, 1'b0, a0, a1, a2);
    chk(!a0 && !a1 && !a2, "R7 port off no ack", {a0, a1, a2}, 0);
    chk(cfgByte(6) == 8'h00, "R7 port off no write", cfgByte(6), 8'h00);
    rstN = 1'b0; wt(4); rstN = 1'b1; wt(4);
    testReset();
    writeFrame(DEV, 8'h06, 8'h44, 1'b0, a0, a1, a2);
    chk(a0 && cfgByte(6) == 8'h44, "R9 port back after reset", cfgByte(6), 8'h44);
  endtask

  initial begin
    wt(5);
    rstN = 1'b1;
    wt(5);
    testReset();
    testWriteRead();
    testStatus();
    testMismatch();
    testExtraByte();
    testGlitch();
    testDisable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wt(150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule